// File: doc/BRIEF.md
# NOR Flash Word Program Engine

This block sits on the host side of a parallel NOR flash and carries out the whole program operation for one word. A client hands it a target address and a data word on a valid/ready request channel. The engine then writes the three-step command preamble and the target word to the flash over a simple synchronous memory bus. After that it keeps reading the target location until the status bits show the outcome.

Completion is detected when bit 7 of a polled read equals bit 7 of the word that was written. If the device raises its time-limit flag (bit 5), the engine reads the location one more time. A match on that read still counts as success. Otherwise the engine writes the read/reset command so the device returns to read mode, and it reports an error. A poll-count limit aborts the operation the same way when the flash never finishes. Each request ends with exactly one single-cycle pulse, either `done` or `error`.

Back-pressure rules:
- The request channel takes a word only on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low for the whole operation.
- The memory command channel holds its command steady until the bus raises `mem_cmd_ready`.
- Read data returns on `mem_rdata_valid` and is never back-pressured.

Top module: `nor_prog_engine`

## Requirements
- R1: Out of reset, `req_ready` is 1, while `mem_cmd_valid`, `done` and `error` are 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is then 0 until the cycle in which `done` or `error` is 1, and it is 1 again in that cycle. No memory command is issued while `req_ready` is 1.
- R3: Every request first issues these four writes in this order, where a write has `mem_cmd_we`=1: data 0x00AA to address 0x555, then data 0x0055 to address 0x2AA, then data 0x00A0 to address 0x555, then the request data to the request address. Bits above 7 of the command data are zero.
- R4: While `mem_cmd_valid` is 1 and `mem_cmd_ready` is 0, the next cycle keeps `mem_cmd_valid` at 1 and keeps `mem_cmd_we`, `mem_addr` and `mem_wdata` unchanged.
- R5: After the fourth write is accepted, every status read (`mem_cmd_we`=0) uses the request address. A new read is issued only after the previous read's data has returned.
- R6: A polled read whose bit 7 equals bit 7 of the written data ends the operation. `done` pulses for one cycle and no further command is issued.
- R7: A polled read with a bit-7 mismatch and bit 5 = 1 causes exactly one further read of the target. If that read matches on bit 7, `done` pulses.
- R8: If that extra read also mismatches on bit 7, the engine writes data 0x00F0 to the request address and then pulses `error`.
- R9: With parameter MAX_POLLS, if MAX_POLLS reads in a row show neither a bit-7 match nor bit 5, the engine writes 0x00F0 to the request address and pulses `error`. Exactly MAX_POLLS reads are issued in this case.
- R10: `done` and `error` are never 1 together, and each is high for one cycle at a time.
- R11: Bit 5 is ignored on a read whose bit 7 matches: the engine pulses `done` with no extra read and no reset write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_addr | input | ADDR_W | Word address to program |
| req_data | input | DATA_W | Word to program |
| done | output | 1 | One-cycle pulse: program finished successfully |
| error | output | 1 | One-cycle pulse: time limit or poll limit hit |
| mem_cmd_valid | output | 1 | Memory command offered |
| mem_cmd_ready | input | 1 | Bus accepts the command this cycle |
| mem_cmd_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Command address |
| mem_wdata | output | DATA_W | Write data (zero on reads) |
| mem_rdata_valid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |

## Verification
The main function is tried with several poll patterns:
- A flash that completes on the first poll, which shows the sequencer moves from the write preamble straight into reading.
- A flash that reports busy for several polls, which shows the engine keeps repeating reads at the target address.
- A final read that matches but also carries bit 5, which distinguishes "bit 5 ignored on a match" from "recheck on bit 5".
- A timeout followed by a matching recheck, and a timeout followed by a failing recheck, which separate the success and reset-then-error branches.
- A flash that stays busy forever, which shows the poll limit counts exactly MAX_POLLS reads.

Stalls on the command bus are mixed in to expose any command that moves before it is accepted. Data words with bit 7 both set and clear show that the comparison follows the written data rather than a fixed polarity.

// File: rtl/nor_prog_pkg.sv
package nor_prog_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_WRITE     = 3'd1,
    ST_POLL_REQ  = 3'd2,
    ST_POLL_WAIT = 3'd3,
    ST_RESET_WR  = 3'd4
  } eng_state_t;

  // Bit positions in a status read.
  localparam int unsigned POLL_DONE_BIT = 7;
  localparam int unsigned POLL_TMO_BIT  = 5;

  // Command bytes and command addresses.
  localparam logic [7:0]  CMD_KEY_A  = 8'hAA;
  localparam logic [7:0]  CMD_KEY_B  = 8'h55;
  localparam logic [7:0]  CMD_PROG   = 8'hA0;
  localparam logic [7:0]  CMD_RESET  = 8'hF0;
  localparam logic [11:0] ADR_KEY_A  = 12'h555;
  localparam logic [11:0] ADR_KEY_B  = 12'h2AA;

  localparam int unsigned NUM_WR_STEPS = 4;

endpackage

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_prog_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16
) (
  input  logic [1:0]        step,
  input  logic              reset_sel,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [DATA_W-1:0] tgt_data,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);

  logic [ADDR_W-1:0] key_a_addr;
  logic [ADDR_W-1:0] key_b_addr;

  // Command addresses widened or trimmed to the bus width.
  generate
    if (ADDR_W >= 12) begin : g_wide
      assign key_a_addr = {{(ADDR_W-12){1'b0}}, ADR_KEY_A};
      assign key_b_addr = {{(ADDR_W-12){1'b0}}, ADR_KEY_B};
    end else begin : g_narrow
      assign key_a_addr = ADR_KEY_A[ADDR_W-1:0];
      assign key_b_addr = ADR_KEY_B[ADDR_W-1:0];
    end
  endgenerate

  function automatic logic [DATA_W-1:0] cmd_word(input logic [7:0] b);
    logic [DATA_W-1:0] w;
    w = '0;
    w[7:0] = b;
    return w;
  endfunction

  always_comb begin
    cmd_addr = tgt_addr;
    cmd_data = tgt_data;
    if (reset_sel) begin
      cmd_addr = tgt_addr;
      cmd_data = cmd_word(CMD_RESET);
    end else begin
      unique case (step)
        2'd0: begin cmd_addr = key_a_addr; cmd_data = cmd_word(CMD_KEY_A); end
        2'd1: begin cmd_addr = key_b_addr; cmd_data = cmd_word(CMD_KEY_B); end
        2'd2: begin cmd_addr = key_a_addr; cmd_data = cmd_word(CMD_PROG);  end
        default: begin cmd_addr = tgt_addr; cmd_data = tgt_data; end
      endcase
    end
  end

endmodule

// File: rtl/nor_poll_eval.sv
module nor_poll_eval
  import nor_prog_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] wdata,
  output logic              match,
  output logic              timeout
);

  logic unused_bits;

  assign match       = (rdata[POLL_DONE_BIT] == wdata[POLL_DONE_BIT]);
  assign timeout     = rdata[POLL_TMO_BIT];
  assign unused_bits = ^{rdata, wdata};

endmodule

// File: rtl/nor_poll_watch.sv
module nor_poll_watch #(
  parameter int unsigned MAX_POLLS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic expired
);

  localparam int unsigned CNT_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_POLLS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
    end else if (tick && cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = (cnt_q == LAST);

  // R9: the busy-poll count never runs past the limit.
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/nor_prog_engine.sv
module nor_prog_engine
  import nor_prog_pkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned MAX_POLLS = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              done,
  output logic              error,
  output logic              mem_cmd_valid,
  input  logic              mem_cmd_ready,
  output logic              mem_cmd_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rdata_valid,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam logic [1:0] LAST_STEP = 2'(NUM_WR_STEPS - 1);

  eng_state_t        state_q;
  logic [1:0]        step_q;
  logic [ADDR_W-1:0] tgt_addr_q;
  logic [DATA_W-1:0] tgt_data_q;
  logic              recheck_q;
  logic              done_q;
  logic              err_q;

  logic [ADDR_W-1:0] seq_addr;
  logic [DATA_W-1:0] seq_data;
  logic              poll_match;
  logic              poll_tmo;
  logic              watch_clr;
  logic              watch_tick;
  logic              watch_exp;
  logic              cmd_fire;
  logic              rd_back;

  nor_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .step      (step_q),
    .reset_sel (state_q == ST_RESET_WR),
    .tgt_addr  (tgt_addr_q),
    .tgt_data  (tgt_data_q),
    .cmd_addr  (seq_addr),
    .cmd_data  (seq_data)
  );

  nor_poll_eval #(.DATA_W(DATA_W)) u_eval (
    .rdata   (mem_rdata),
    .wdata   (tgt_data_q),
    .match   (poll_match),
    .timeout (poll_tmo)
  );

  nor_poll_watch #(.MAX_POLLS(MAX_POLLS)) u_watch (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (watch_clr),
    .tick    (watch_tick),
    .expired (watch_exp)
  );

  // Bus side
  always_comb begin
    req_ready     = (state_q == ST_IDLE);
    mem_cmd_valid = (state_q == ST_WRITE) || (state_q == ST_POLL_REQ) ||
                    (state_q == ST_RESET_WR);
    mem_cmd_we    = (state_q != ST_POLL_REQ);
    mem_addr      = (state_q == ST_POLL_REQ) ? tgt_addr_q : seq_addr;
    mem_wdata     = (state_q == ST_POLL_REQ) ? '0 : seq_data;
  end

  assign cmd_fire   = mem_cmd_valid && mem_cmd_ready;
  assign rd_back    = (state_q == ST_POLL_WAIT) && mem_rdata_valid;
  assign watch_clr  = (state_q == ST_WRITE) && cmd_fire && (step_q == LAST_STEP);
  assign watch_tick = rd_back && !poll_match && !poll_tmo && !recheck_q && !watch_exp;

  // Sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      step_q     <= '0;
      tgt_addr_q <= '0;
      tgt_data_q <= '0;
      recheck_q  <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            tgt_addr_q <= req_addr;
            tgt_data_q <= req_data;
            step_q     <= '0;
            recheck_q  <= 1'b0;
            state_q    <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (mem_cmd_ready) begin
            if (step_q == LAST_STEP) begin
              state_q <= ST_POLL_REQ;
            end else begin
              step_q <= step_q + 1'b1;
            end
          end
        end
        ST_POLL_REQ: begin
          if (mem_cmd_ready) state_q <= ST_POLL_WAIT;
        end
        ST_POLL_WAIT: begin
          if (mem_rdata_valid) begin
            if (poll_match) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else if (recheck_q) begin
              state_q <= ST_RESET_WR;
            end else if (poll_tmo) begin
              recheck_q <= 1'b1;
              state_q   <= ST_POLL_REQ;
            end else if (watch_exp) begin
              state_q <= ST_RESET_WR;
            end else begin
              state_q <= ST_POLL_REQ;
            end
          end
        end
        ST_RESET_WR: begin
          if (mem_cmd_ready) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done  = done_q;
  assign error = err_q;

  // R2: taking a request drops ready on the next cycle.
  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R2: no bus traffic while idle.
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_cmd_valid);

  // R4: an unaccepted command holds.
  p_hold_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && !mem_cmd_ready |=> mem_cmd_valid && $stable(mem_cmd_we) &&
    $stable(mem_addr) && $stable(mem_wdata));

  // R6: success follows a returned read.
  p_done_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_rdata_valid));

  // R8: error follows an accepted write.
  p_err_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> $past(mem_cmd_valid && mem_cmd_ready && mem_cmd_we));

  // R10: outcomes exclusive and single-cycle.
  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_err_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> !error);

endmodule

// File: tb/tb_nor_prog_engine.sv
module tb_nor_prog_engine;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int MAXP = 5;
  localparam int WATCHDOG = 20000;

  localparam int M_OK = 0, M_MATCH5 = 1, M_TO_OK = 2, M_TO_FAIL = 3, M_HANG = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic done, error;
  logic mem_cmd_valid;
  logic mem_cmd_ready = 0;
  logic mem_cmd_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic mem_rdata_valid = 0;
  logic [DW-1:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_prog_engine #(.ADDR_W(AW), .DATA_W(DW), .MAX_POLLS(MAXP)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data),
    .done(done), .error(error),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
    .mem_cmd_we(mem_cmd_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata_valid(mem_rdata_valid), .mem_rdata(mem_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;

  // scoreboard queues
  logic [AW+DW:0] exp_ops[$];
  string          exp_op_tag[$];
  logic           exp_err[$];
  string          exp_out_tag[$];

  // flash model settings
  int            mode = M_OK;
  int            nbusy = 0;
  logic [DW-1:0] cur_data = '0;
  bit            stall_en = 0;
  int            rd_idx = 0;
  bit            pend_rd = 0;
  bit            busy = 0;
  bit            monitor_on = 0;
  int            cyc = 0;
  bit            held = 0;
  logic [AW+DW:0] held_op;

  task automatic check(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] busy_word(input logic [DW-1:0] d);
    return (d ^ DW'(16'h0080)) & ~DW'(16'h0020);
  endfunction

  function automatic logic [DW-1:0] model_resp(input int k);
    logic [DW-1:0] b;
    b = busy_word(cur_data);
    if (mode == M_HANG) return b;
    if (k < nbusy) return b;
    case (mode)
      M_OK:      return cur_data;
      M_MATCH5:  return cur_data | DW'(16'h0020);
      M_TO_OK:   return (k == nbusy) ? (b | DW'(16'h0020)) : cur_data;
      default:   return b | DW'(16'h0020);
    endcase
  endfunction

  // Monitor and bus responder
  always @(negedge clk) begin
    if (monitor_on) begin
      cyc++;
      if (done || error) begin
        if (exp_err.size() == 0) begin
          check(0, "R10 unexpected outcome", {62'd0, done, error}, 64'd0);
        end else begin
          logic e; string t;
          e = exp_err.pop_front();
          t = exp_out_tag.pop_front();
          check(done == !e && error == e, t, {62'd0, done, error}, {62'd0, !e, e});
          check(exp_ops.size() == 0, {t, " missing bus ops"}, 64'(exp_ops.size()), 64'd0);
        end
        check(req_ready == 1'b1, "R2 ready back with outcome", 64'(req_ready), 64'd1);
        busy = 0;
      end else if (busy) begin
        check(req_ready == 1'b0, "R2 ready low while busy", 64'(req_ready), 64'd0);
      end

      mem_rdata_valid = 0;
      if (pend_rd) begin
        mem_rdata_valid = 1;
        mem_rdata = model_resp(rd_idx);
        rd_idx++;
        pend_rd = 0;
      end

      if (held) begin
        check(mem_cmd_valid && {mem_cmd_we, mem_addr, mem_wdata} == held_op,
              "R4 stalled command held", 64'({mem_cmd_we, mem_addr, mem_wdata}), 64'(held_op));
      end

      mem_cmd_ready = !(stall_en && (cyc % 3 == 0));
      held = mem_cmd_valid && !mem_cmd_ready;
      held_op = {mem_cmd_we, mem_addr, mem_wdata};

      if (mem_cmd_valid && mem_cmd_ready) begin
        if (exp_ops.size() == 0) begin
          check(0, "R6 extra bus command", 64'({mem_cmd_we, mem_addr, mem_wdata}), 64'd0);
        end else begin
          logic [AW+DW:0] e; string t; logic [AW+DW:0] g;
          e = exp_ops.pop_front();
          t = exp_op_tag.pop_front();
          g = {mem_cmd_we, mem_addr, mem_wdata};
          if (e[AW+DW]) check(g == e, t, 64'(g), 64'(e));
          else check(g[AW+DW:DW] == e[AW+DW:DW], t, 64'(g), 64'(e));
        end
        if (!mem_cmd_we) pend_rd = 1;
      end

      if (req_valid && req_ready) begin
        busy = 1;
        rd_idx = 0;
      end
    end
  end

  task automatic push_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d, input string t);
    exp_ops.push_back({we, a, d});
    exp_op_tag.push_back(t);
  endtask

  task automatic run(input int m, input int b, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input bit st, input string otag);
    int nrd;
    push_op(1, AW'(20'h00555), DW'(16'h00AA), "R3 unlock 1");
    push_op(1, AW'(20'h002AA), DW'(16'h0055), "R3 unlock 2");
    push_op(1, AW'(20'h00555), DW'(16'h00A0), "R3 setup");
    push_op(1, a, d, "R3 target write");
    case (m)
      M_OK, M_MATCH5:      nrd = b + 1;
      M_TO_OK, M_TO_FAIL:  nrd = b + 2;
      default:             nrd = MAXP;
    endcase
    for (int i = 0; i < nrd; i++) begin
      push_op(0, a, '0, (i >= b && (m == M_TO_OK || m == M_TO_FAIL)) ? "R7 recheck read" : "R5 poll read");
    end
    if (m == M_TO_FAIL) push_op(1, a, DW'(16'h00F0), "R8 reset write");
    if (m == M_HANG)    push_op(1, a, DW'(16'h00F0), "R9 reset write");
    exp_err.push_back(m == M_TO_FAIL || m == M_HANG);
    exp_out_tag.push_back(otag);
    mode = m; nbusy = b; cur_data = d; stall_en = st;
    @(posedge clk); #1;
    req_valid = 1; req_addr = a; req_data = d;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 0;
    while (exp_err.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(req_ready == 1, "R1 ready after reset", 64'(req_ready), 64'd1);
    check(mem_cmd_valid == 0, "R1 bus idle after reset", 64'(mem_cmd_valid), 64'd0);
    check(done == 0 && error == 0, "R1 no outcome after reset", {62'd0, done, error}, 64'd0);
    monitor_on = 1;

    run(M_OK,      0, 20'h01234, 16'h1234, 0, "R6 immediate completion");
    run(M_OK,      3, 20'hABCDE, 16'hBEEF, 1, "R6 completion after busy polls");
    run(M_MATCH5,  1, 20'h00010, 16'h00A5, 0, "R11 match with bit5 set");
    run(M_TO_OK,   2, 20'h7FFFF, 16'h5A3C, 1, "R7 timeout then match");
    run(M_TO_FAIL, 1, 20'h00400, 16'hC0DE, 0, "R8 timeout then error");
    run(M_HANG,    0, 20'h33333, 16'h0F0F, 1, "R9 poll limit error");
    run(M_OK,      1, 20'h00002, 16'hFF80, 0, "R10 recovery after error");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule